// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address for a RISC-style pipeline in which every jump and every call has exactly one architectural delay slot. The instruction that follows a transfer always executes before the transfer's target. Each cycle the issue stage presents the kind of control transfer it is issuing: none, jump or call. It also presents a target word address and, for a call, the index of the register that receives the return address. The sequencer answers with the address of the next instruction to issue.

The state is a pair of word addresses. The current address names the instruction being issued. The successor address names the one after it. A transfer loads its target into the successor, and every issue moves the successor into the current address. Because of this, a jump or call sitting in another transfer's delay slot resolves in a well-defined way. The return address a call writes is the address of its own delay-slot instruction plus one. When a call sits in a jump's delay slot, the jump target runs as the call's delay slot, the call target follows, and the return lands one past the jump target.

A build-time switch chooses between two policies for a transfer found in a delay slot. Under the default policy the transfer is legal. Under the strict policy it is suppressed, and the sequencer raises a one-cycle trap and redirects fetch to a fixed vector.

Top module: `dbr_fetch_seq`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, the successor address to 1 and the in-slot flag to clear, and holds the link write strobe and the trap output low. The first plain issue after reset fetches address 1.
- R2: An issue with transfer kind none (code 2'b00) makes the fetch address, one clock later, equal to the previous fetch address plus one, continuing the successor chain.
- R3: An issue with kind jump (code 2'b01) at address A makes the next fetch address A+1 (the delay slot). The issue after that fetches the jump target.
- R4: An issue with kind call (code 2'b10) behaves like a jump for sequencing. One clock later it pulses the link write strobe for one cycle, with the link register index equal to the index presented with the call. For a call not in a delay slot, the link address equals the call's address plus two.
- R5: The link address is the address of the call's delay-slot instruction plus one. For a call issued in a jump's delay slot, the fetch order is the jump target and then the call target, and the link address is the jump target plus one.
- R6: Under the default policy, a jump issued in a jump's delay slot is honoured. For a jump to T1 at A followed by a jump to T2 at A+1, the fetch order is A+1, T1, T2.
- R7: While the issue-valid input is low, the fetch address, the successor address and the in-slot flag hold, whatever the transfer inputs carry, and the link write strobe stays low.
- R8: Under the strict policy, a jump or call issued in a delay slot is suppressed. One clock later the trap output is high for exactly one cycle, the fetch address equals the trap vector, and no link write occurs. The next plain issue fetches the trap vector plus one.
- R9: The reserved transfer code 2'b11 is treated as kind none: sequential flow, no link write, no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| xfer_kind | input | 2 | Transfer kind: 00 none, 01 jump, 10 call, 11 reserved (none) |
| xfer_target | input | AW | Target word address of a jump or call |
| link_sel | input | LW | Register index that receives a call's return address |
| fetch_addr | output | AW | Registered address of the next instruction to issue |
| link_wr | output | 1 | Registered write strobe for the return address |
| link_addr | output | AW | Registered return address |
| link_idx | output | LW | Registered destination register index for the return address |
| slot_trap | output | 1 | One-cycle pulse: a transfer was found in a delay slot (strict policy) |

## Verification
The assertions assume that reset is held for at least one clock before the first issue. They also assume that the transfer kind and target are read only in cycles where issue-valid is high; the hold property is written so that junk on those inputs during a stall is allowed. The stimulus changes every input on the falling edge and deliberately puts transfer codes and targets on the bus during stalled cycles. The strict-policy instance is reset before its directed run, so the traps it may take during the shared table walk do not leak into its checks.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    XK_NONE = 2'b00,
    XK_JUMP = 2'b01,
    XK_CALL = 2'b10,
    XK_RSVD = 2'b11
  } xfer_kind_e;

endpackage

// File: rtl/dbr_slot_guard.sv
module dbr_slot_guard
  import dbr_pkg::*;
#(
  parameter bit STRICT = 1'b0
) (
  input  logic       issue,
  input  logic [1:0] kind_raw,
  input  logic       in_slot,
  output logic       take_xfer,
  output logic       take_call,
  output logic       raise_trap
);

  xfer_kind_e kind;
  logic       is_xfer;

  assign kind    = xfer_kind_e'(kind_raw);
  assign is_xfer = (kind == XK_JUMP) || (kind == XK_CALL);

  generate
    if (STRICT) begin : g_strict
      assign raise_trap = issue & is_xfer & in_slot;
    end else begin : g_lenient
      logic unused_slot;
      assign unused_slot = in_slot;
      assign raise_trap  = 1'b0;
    end
  endgenerate

  assign take_xfer = issue & is_xfer & ~raise_trap;
  assign take_call = take_xfer & (kind == XK_CALL);

endmodule

// File: rtl/dbr_pc_pair.sv
module dbr_pc_pair #(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   TRAP_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          take_xfer,
  input  logic          raise_trap,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] npc,
  output logic          in_slot
);

  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      npc     <= ONE;
      in_slot <= 1'b0;
    end else if (issue) begin
      if (raise_trap) begin
        pc      <= TRAP_VEC;
        npc     <= TRAP_VEC + ONE;
        in_slot <= 1'b0;
      end else begin
        pc      <= npc;
        npc     <= take_xfer ? target : npc + ONE;
        in_slot <= take_xfer;
      end
    end
  end

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(pc) && $stable(npc) && $stable(in_slot));

  // R2
  successor_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !raise_trap) |=> pc == $past(npc));

  // R3
  target_load_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && take_xfer) |=> (npc == $past(target)) && in_slot);

  // R8
  trap_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && raise_trap) |=> (pc == TRAP_VEC) && !in_slot);

endmodule

// File: rtl/dbr_link_unit.sv
module dbr_link_unit #(
  parameter int AW = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_call,
  input  logic [AW-1:0] npc,
  input  logic [LW-1:0] sel,
  output logic          wr,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr   <= 1'b0;
      addr <= '0;
      idx  <= '0;
    end else begin
      wr <= take_call;
      if (take_call) begin
        addr <= npc + AW'(1);
        idx  <= sel;
      end
    end
  end

  // R4
  link_follow_chk: assert property (@(posedge clk) disable iff (rst)
    take_call |=> wr && (idx == $past(sel)));

  // R5
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    take_call |=> addr == $past(npc) + AW'(1));

  // R4
  link_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !take_call |=> !wr);

endmodule

// File: rtl/dbr_fetch_seq.sv
module dbr_fetch_seq #(
  parameter int            AW          = 16,
  parameter int            LW          = 5,
  parameter bit            SLOT_STRICT = 1'b0,
  parameter logic [AW-1:0] TRAP_VEC    = AW'(256)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [1:0]    xfer_kind,
  input  logic [AW-1:0] xfer_target,
  input  logic [LW-1:0] link_sel,
  output logic [AW-1:0] fetch_addr,
  output logic          link_wr,
  output logic [AW-1:0] link_addr,
  output logic [LW-1:0] link_idx,
  output logic          slot_trap
);

  logic          take_xfer;
  logic          take_call;
  logic          raise_trap;
  logic          in_slot;
  logic [AW-1:0] pc;
  logic [AW-1:0] npc;

  dbr_slot_guard #(
    .STRICT(SLOT_STRICT)
  ) u_guard (
    .issue     (issue_valid),
    .kind_raw  (xfer_kind),
    .in_slot   (in_slot),
    .take_xfer (take_xfer),
    .take_call (take_call),
    .raise_trap(raise_trap)
  );

  dbr_pc_pair #(
    .AW      (AW),
    .TRAP_VEC(TRAP_VEC)
  ) u_pair (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue_valid),
    .take_xfer (take_xfer),
    .raise_trap(raise_trap),
    .target    (xfer_target),
    .pc        (pc),
    .npc       (npc),
    .in_slot   (in_slot)
  );

  dbr_link_unit #(
    .AW(AW),
    .LW(LW)
  ) u_link (
    .clk      (clk),
    .rst      (rst),
    .take_call(take_call),
    .npc      (npc),
    .sel      (link_sel),
    .wr       (link_wr),
    .addr     (link_addr),
    .idx      (link_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) slot_trap <= 1'b0;
    else     slot_trap <= raise_trap;
  end

  assign fetch_addr = pc;

  // R8
  trap_vector_chk: assert property (@(posedge clk) disable iff (rst)
    slot_trap |-> (fetch_addr == TRAP_VEC) && !link_wr);

  // R8
  trap_single_chk: assert property (@(posedge clk) disable iff (rst)
    slot_trap |=> !slot_trap);

  // R9
  reserved_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && xfer_kind == 2'b11) |=> !link_wr && !slot_trap);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && !link_wr && !slot_trap);

endmodule

// File: tb/sim_dbr_fetch_seq.sv
module sim_dbr_fetch_seq;

  localparam int AW = 16;
  localparam int LW = 5;
  localparam logic [AW-1:0] TVEC = 16'h0080;
  localparam int NV = 17;
  localparam int VW = 1 + 2 + AW + LW + AW + 1 + AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          issue_valid;
  logic [1:0]    xfer_kind;
  logic [AW-1:0] xfer_target;
  logic [LW-1:0] link_sel;

  logic [AW-1:0] fa0, la0, fa1, la1;
  logic          lw0, tr0, lw1, tr1;
  logic [LW-1:0] li0, li1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbr_fetch_seq #(.AW(AW), .LW(LW), .SLOT_STRICT(1'b0), .TRAP_VEC(TVEC)) u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .xfer_kind(xfer_kind),
    .xfer_target(xfer_target), .link_sel(link_sel), .fetch_addr(fa0),
    .link_wr(lw0), .link_addr(la0), .link_idx(li0), .slot_trap(tr0));

  dbr_fetch_seq #(.AW(AW), .LW(LW), .SLOT_STRICT(1'b1), .TRAP_VEC(TVEC)) u1 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .xfer_kind(xfer_kind),
    .xfer_target(xfer_target), .link_sel(link_sel), .fetch_addr(fa1),
    .link_wr(lw1), .link_addr(la1), .link_idx(li1), .slot_trap(tr1));

  // {valid, kind, target, link, exp_fetch, exp_link_wr, exp_link_addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd1,   1'b0, 16'd0},   // R2
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd2,   1'b0, 16'd0},   // R2
    {1'b1, 2'd1, 16'd40,  5'd0, 16'd3,   1'b0, 16'd0},   // R3 jump at 2
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd40,  1'b0, 16'd0},   // R3 slot then target
    {1'b1, 2'd2, 16'd100, 5'd7, 16'd41,  1'b1, 16'd42},  // R4 call at 40
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd100, 1'b0, 16'd0},   // R4
    {1'b1, 2'd1, 16'd200, 5'd0, 16'd101, 1'b0, 16'd0},   // R5 jump at 100
    {1'b1, 2'd2, 16'd300, 5'd3, 16'd200, 1'b1, 16'd201}, // R5 call in slot
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd300, 1'b0, 16'd0},   // R5
    {1'b0, 2'd1, 16'd5,   5'd1, 16'd300, 1'b0, 16'd0},   // R7 stall
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd301, 1'b0, 16'd0},   // R2
    {1'b1, 2'd1, 16'd500, 5'd0, 16'd302, 1'b0, 16'd0},   // R6 jump at 301
    {1'b0, 2'd2, 16'd9,   5'd2, 16'd302, 1'b0, 16'd0},   // R7 stall in slot
    {1'b1, 2'd1, 16'd600, 5'd0, 16'd500, 1'b0, 16'd0},   // R6 jump in slot
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd600, 1'b0, 16'd0},   // R6
    {1'b1, 2'd3, 16'd777, 5'd4, 16'd601, 1'b0, 16'd0},   // R9 reserved
    {1'b1, 2'd0, 16'd0,   5'd0, 16'd602, 1'b0, 16'd0}    // R9
  };

  localparam string VTAG [NV] = '{
    "R2", "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R5",
    "R7", "R2", "R6", "R7", "R6", "R6", "R9", "R9"
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k,
                       input logic [AW-1:0] t, input logic [LW-1:0] l);
    @(negedge clk);
    issue_valid = v;
    xfer_kind   = k;
    xfer_target = t;
    link_sel    = l;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst         = 1'b1;
    issue_valid = 1'b0;
    xfer_kind   = 2'd0;
    xfer_target = '0;
    link_sel    = '0;
    repeat (2) @(posedge clk);
    #2;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "fetch after reset", 32'(fa0), 0);
    chk("R1", "link_wr after reset", 32'(lw0), 0);
    chk("R1", "trap after reset", 32'(tr0), 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1], v[VW-2 -: 2], v[VW-4 -: AW], v[VW-4-AW -: LW]);
      chk(VTAG[i], $sformatf("vec %0d fetch", i), 32'(fa0), 32'(v[AW+1+AW-1 -: AW]));
      chk(VTAG[i], $sformatf("vec %0d link_wr", i), 32'(lw0), 32'(v[AW]));
      chk(VTAG[i], $sformatf("vec %0d trap", i), 32'(tr0), 0);
      if (v[AW]) begin
        chk(VTAG[i], $sformatf("vec %0d link_addr", i), 32'(la0), 32'(v[AW-1:0]));
        chk(VTAG[i], $sformatf("vec %0d link_idx", i), 32'(li0), 32'(v[VW-4-AW -: LW]));
      end
    end

    // R1: reset mid-run, then first plain issue fetches 1
    do_reset();
    chk("R1", "fetch after second reset", 32'(fa0), 0);
    drive(1'b1, 2'd0, '0, '0);
    chk("R1", "first plain issue", 32'(fa0), 1);

    // R8: strict instance, call in a jump's delay slot traps
    do_reset();
    chk("R8", "strict reset fetch", 32'(fa1), 0);
    drive(1'b1, 2'd1, 16'd20, '0);
    chk("R8", "jump not in slot, no trap", 32'(tr1), 0);
    chk("R8", "jump slot fetch", 32'(fa1), 1);
    drive(1'b0, 2'd2, 16'd50, 5'd6);
    chk("R8", "stall in slot, no trap", 32'(tr1), 0);
    drive(1'b1, 2'd2, 16'd50, 5'd6);
    chk("R8", "trap pulse", 32'(tr1), 1);
    chk("R8", "trap vector fetch", 32'(fa1), 32'(TVEC));
    chk("R8", "no link write on trap", 32'(lw1), 0);
    drive(1'b1, 2'd0, '0, '0);
    chk("R8", "trap drops", 32'(tr1), 0);
    chk("R8", "after vector", 32'(fa1), 32'(TVEC) + 1);
    // R4: normal call still works under strict policy
    drive(1'b1, 2'd2, 16'd10, 5'd9);
    chk("R4", "strict call link_wr", 32'(lw1), 1);
    chk("R4", "strict call link_addr", 32'(la1), 32'(TVEC) + 3);
    chk("R4", "strict call link_idx", 32'(li1), 9);
    drive(1'b1, 2'd0, '0, '0);
    chk("R4", "strict call target", 32'(fa1), 10);
    chk("R4", "link strobe one cycle", 32'(lw1), 0);

    finish_run();
  end

endmodule